// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. Software programs a clock divider and sets an enable bit. It then writes one command word holding a start flag, a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block produces the management clock and runs one complete clause-22 frame on the bidirectional data line. When the frame ends it clears the start flag. For reads it also stores the returned data and an acknowledge flag in the same command word.

A second path hands the pins to software. When the mode register selects manual operation, three bits of a pin register drive the clock, the output-enable and the data line directly. Software can also read the level that is present on the data line. The sequencer is held inactive for as long as manual operation is selected.

The register bus is a plain synchronous port. A write takes effect on the clock edge where `bus_wen` is high. Read data is combinational from `bus_addr`. Register selects are: 0 control, 1 command, 2 mode, 3 pin.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 0x800000FF: the idle flag is set, the engine is disabled and the divider is 0xFF. MDC is low and the data line is released (output-enable low).
- R2: In the control register, bit 30 enables the engine and bits 15:0 hold the divider. Bit 31 is a read-only idle flag: it reads 0 exactly when the engine is enabled and manual mode is off.
- R3: While the engine runs, one MDC period is (divider + 1) clock cycles. A divider of 0 behaves as 1, giving a 2-cycle period.
- R4: The command register has this layout: bit 31 GO, bit 30 WRITE (1 = write, 0 = read), bit 29 ACK, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. Writing GO=1 starts a frame only when the engine is enabled and manual mode is off. GO reads 1 from the start until the frame completes, then reads 0.
- R5: Each frame begins with 32 ones, then start bits 0,1, then opcode 1,0 for a read or 0,1 for a write. The 5-bit PHY address and the 5-bit register address follow, each MSB first.
- R6: A write frame drives turnaround bits 1,0 and then 16 data bits MSB first. The master drives the line for all 64 bit times.
- R7: A read frame releases the line after the register address, so the master drives 46 bits. A low level on the second turnaround bit is the acknowledge. After an acknowledge, the 16 following bits are captured MSB first, ACK reads 1 and the data field holds them.
- R8: A read without acknowledge still runs all 64 MDC cycles. ACK then reads 0 and the data field reads 0xFFFF.
- R9: The master changes its driven data only as MDC falls and samples the line as MDC rises.
- R10: Clearing the enable bit aborts a frame in progress. By the second clock edge after the register write, GO reads 0, MDC is low and the line is released. A later frame runs normally.
- R11: Bit 31 of the mode register selects manual mode. In manual mode, pin-register bit 2 drives MDC, bit 1 drives the output-enable and bit 0 drives the data line. Pin-register bit 0 reads back the written value while the output-enable bit is 1, and the sampled line level while it is 0. A GO write in manual mode is ignored.
- R12: A command write that arrives while GO reads 1 is ignored. The fields of the running command stay unchanged and no second frame is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output-enable |
| mdio_i | input | 1 | Sampled data line level |

## Verification
A wrong bit counter or sequencer state appears at the pins within a single frame. The captured frame would be longer or shorter than 64 MDC rises, the number of driven bits would differ from 64 or 46, or GO would stay set or clear early. A corrupted divider count shows up within one MDC period as a wrong high-to-high interval. A stale command or acknowledge register shows up as soon as software reads the command word after GO falls. An abort path that fails to reset shows up two clock edges after the enable bit is cleared, as a lingering MDC, output-enable or GO.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int IDX_W = 6;
    localparam logic [IDX_W-1:0] LAST_IDX       = 6'd63;
    localparam logic [IDX_W-1:0] LAST_RD_DRIVEN = 6'd45;
    localparam logic [IDX_W-1:0] TA2_IDX        = 6'd47;
    localparam logic [IDX_W-1:0] DATA_IDX       = 6'd48;

    localparam int CMD_GO_BIT = 31;
    localparam int CMD_WR_BIT = 30;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CMD    = 2'd1,
        REG_MODE   = 2'd2,
        REG_MANUAL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ALIGN,
        SQ_SHIFT
    } seq_state_e;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] data;
    } mdio_cmd_t;

    // Whole frame as driven by the master; read turnaround and data are
    // filled with ones (line released).
    function automatic logic [63:0] make_frame(mdio_cmd_t c);
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] tail;
        opc  = c.wr ? 2'b01 : 2'b10;
        ta   = c.wr ? 2'b10 : 2'b11;
        tail = c.wr ? c.data : 16'hFFFF;
        return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.ra, ta, tail};
    endfunction

    function automatic mdio_cmd_t unpack_cmd(logic [31:0] w);
        mdio_cmd_t c;
        c.wr   = w[CMD_WR_BIT];
        c.ra   = w[25:21];
        c.phy  = w[20:16];
        c.data = w[15:0];
        return c;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tk,
    output logic             fall_tk
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;

    always_comb begin
        eff     = (div == '0) ? DIV_W'(1) : div;
        half    = eff >> 1;
        rise_tk = run && (cnt == half);
        fall_tk = run && (cnt == eff);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            if (cnt >= eff) cnt <= '0;
            else            cnt <= cnt + 1'b1;
            if (fall_tk)      mdc <= 1'b0;
            else if (rise_tk) mdc <= 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_tk,
    input  logic        fall_tk,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        ack,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);

    seq_state_e       st;
    logic [63:0]      frame;
    logic [IDX_W-1:0] idx;
    logic             wr_q;
    logic [15:0]      shreg;
    logic             ack_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st      <= SQ_IDLE;
            frame   <= '0;
            idx     <= '0;
            wr_q    <= 1'b0;
            shreg   <= '0;
            ack_q   <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        frame <= make_frame(cmd);
                        wr_q  <= cmd.wr;
                        ack_q <= 1'b0;
                        shreg <= '0;
                        st    <= SQ_ALIGN;
                    end
                end
                SQ_ALIGN: begin
                    if (fall_tk) begin
                        st      <= SQ_SHIFT;
                        idx     <= '0;
                        mdio_o  <= frame[LAST_IDX];
                        mdio_oe <= 1'b1;
                    end
                end
                SQ_SHIFT: begin
                    if (fall_tk) begin
                        if (idx == LAST_IDX) begin
                            st      <= SQ_IDLE;
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b1;
                            done    <= 1'b1;
                        end else begin
                            idx     <= idx + 1'b1;
                            mdio_o  <= frame[LAST_IDX - 6'd1 - idx];
                            mdio_oe <= wr_q || (idx < LAST_RD_DRIVEN);
                        end
                    end else if (rise_tk && !wr_q) begin
                        if (idx == TA2_IDX)
                            ack_q <= ~mdio_i;
                        else if (idx >= DATA_IDX)
                            shreg <= {shreg[14:0], mdio_i};
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy    = (st != SQ_IDLE);
    assign ack     = ack_q;
    assign rd_data = ack_q ? shreg : 16'hFFFF;

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int               DIV_W   = 16,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(8'hFF)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic             en_q;
    logic [DIV_W-1:0] div_q;
    logic             man_sel_q;
    logic [2:0]       man_bits_q;
    mdio_cmd_t        cmd_q;
    logic             ack_q;

    logic             run;
    logic             go_busy;
    logic             start;
    reg_sel_e         sel;
    mdio_cmd_t        cmd_in;

    logic             gen_mdc, rise_tk, fall_tk;
    logic             seq_busy, seq_done, seq_ack;
    logic [15:0]      seq_rd;
    logic             seq_o, seq_oe;
    logic [15:0]      div_ext;
    logic             unused_wbits;

    assign sel     = reg_sel_e'(bus_addr);
    assign cmd_in  = unpack_cmd(bus_wdata);
    assign run     = en_q && !man_sel_q;
    assign go_busy = seq_busy || seq_done;
    assign start   = bus_wen && (sel == REG_CMD) && bus_wdata[CMD_GO_BIT]
                     && run && !go_busy;
    assign unused_wbits = ^{bus_wdata[29:26], bus_wdata[CMD_GO_BIT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            div_q      <= DIV_RST;
            man_sel_q  <= 1'b0;
            man_bits_q <= 3'b000;
            cmd_q      <= '0;
            ack_q      <= 1'b0;
        end else begin
            if (bus_wen) begin
                case (sel)
                    REG_CTRL: begin
                        en_q  <= bus_wdata[30];
                        div_q <= bus_wdata[DIV_W-1:0];
                    end
                    REG_CMD: begin
                        if (!go_busy) begin
                            cmd_q <= cmd_in;
                            ack_q <= 1'b0;
                        end
                    end
                    REG_MODE:   man_sel_q  <= bus_wdata[31];
                    REG_MANUAL: man_bits_q <= bus_wdata[2:0];
                    default: ;
                endcase
            end
            if (seq_done) begin
                ack_q <= seq_ack;
                if (!cmd_q.wr) cmd_q.data <= seq_rd;
            end
        end
    end

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div     (div_q),
        .mdc     (gen_mdc),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .abort   (!run),
        .start   (start),
        .cmd     (cmd_in),
        .rise_tk (rise_tk),
        .fall_tk (fall_tk),
        .mdio_i  (mdio_i),
        .busy    (seq_busy),
        .done    (seq_done),
        .ack     (seq_ack),
        .rd_data (seq_rd),
        .mdio_o  (seq_o),
        .mdio_oe (seq_oe)
    );

    always_comb begin
        div_ext = '0;
        div_ext[DIV_W-1:0] = div_q;
        case (sel)
            REG_CTRL:   bus_rdata = {~run, en_q, 14'b0, div_ext};
            REG_CMD:    bus_rdata = {go_busy, cmd_q.wr, ack_q, 3'b000,
                                     cmd_q.ra, cmd_q.phy, cmd_q.data};
            REG_MODE:   bus_rdata = {man_sel_q, 31'b0};
            REG_MANUAL: bus_rdata = {29'b0, man_bits_q[2], man_bits_q[1],
                                     man_bits_q[1] ? man_bits_q[0] : mdio_i};
            default:    bus_rdata = '0;
        endcase
    end

    assign mdc_o   = man_sel_q ? man_bits_q[2] : gen_mdc;
    assign mdio_oe = man_sel_q ? man_bits_q[1] : seq_oe;
    assign mdio_o  = man_sel_q ? man_bits_q[0] : seq_o;

endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        man_sel,
    input logic        start,
    input logic        seq_busy,
    input logic        seq_done,
    input logic        seq_ack,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        ack_q,
    input logic        cmd_wr,
    input logic [4:0]  cmd_phy,
    input logic [4:0]  cmd_ra,
    input logic [15:0] cmd_data
);

    // R9
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)))
        |-> (!mdc_o && $past(mdc_o)));

    // R4
    go_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_busy) |-> $past(start));

    // R10
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !man_sel) |=> (!seq_busy && !mdio_oe && !mdc_o));

    // R7
    ack_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> !cmd_wr);

    // R12
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        seq_busy |=> ($stable(cmd_phy) && $stable(cmd_ra) && $stable(cmd_wr)));

    // R8
    noack_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_done && !seq_ack && !cmd_wr) |=> (cmd_data == 16'hFFFF && !ack_q));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .man_sel  (man_sel_q),
    .start    (start),
    .seq_busy (seq_busy),
    .seq_done (seq_done),
    .seq_ack  (seq_ack),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .ack_q    (ack_q),
    .cmd_wr   (cmd_q.wr),
    .cmd_phy  (cmd_q.phy),
    .cmd_ra   (cmd_q.ra),
    .cmd_data (cmd_q.data)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        mdc_o, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    mdio_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc_o     (mdc_o),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] exp_frame_q[$];
    int          exp_oe_q[$];

    bit          mon_kill = 1'b0;
    bit          mon_active = 1'b0;
    int          mon_idx = 0;
    logic [63:0] cap = '0;
    int          oecnt = 0;
    logic        prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b1;
    int          mon_frames = 0;
    int          edge_viol = 0;
    bit          resp_ack = 1'b0;
    logic [15:0] resp_data = '0;
    bit          man_in_en = 1'b0;
    logic        man_in_val = 1'b1;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(bit wr, logic [4:0] phy,
                                              logic [4:0] ra, logic [15:0] d, bit ack);
        logic [1:0]  opc;
        logic [1:0]  ta;
        logic [15:0] tail;
        opc  = wr ? 2'b01 : 2'b10;
        ta   = wr ? 2'b10 : (ack ? 2'b10 : 2'b11);
        tail = (wr || ack) ? d : 16'hFFFF;
        return {32'hFFFF_FFFF, 2'b01, opc, phy, ra, ta, tail};
    endfunction

    // Monitor (scoreboard consumer) and PHY responder
    always @(negedge clk) begin
        logic        line;
        logic [63:0] e;
        int          eo;
        if (rst || mon_kill) begin
            mon_active = 1'b0;
            mon_idx    = 0;
        end else begin
            if (!mon_active && mdio_oe && !prev_oe) begin
                mon_active = 1'b1;
                mon_idx    = 0;
                cap        = '0;
                oecnt      = 0;
            end
            if (mon_active && mdio_oe && prev_oe && (mdio_o !== prev_o) && !(prev_mdc && !mdc_o))
                edge_viol++;
            if (mon_active && mdc_o && !prev_mdc) begin
                line = mdio_oe ? mdio_o : mdio_i;
                cap[63 - mon_idx] = line;
                if (mdio_oe) oecnt++;
                mon_idx++;
                if (mon_idx == 64) begin
                    mon_active = 1'b0;
                    mon_frames++;
                    if (exp_frame_q.size() == 0) begin
                        check("R12 unexpected frame on the line", 64'd1, 64'd0);
                    end else begin
                        e  = exp_frame_q.pop_front();
                        eo = exp_oe_q.pop_front();
                        check("R5 R6 R7 frame bits", cap, e);
                        check("R6 R7 driven bit count", 64'(oecnt), 64'(eo));
                    end
                end
            end
        end
        prev_mdc = mdc_o;
        prev_oe  = mdio_oe;
        prev_o   = mdio_o;
        if (man_in_en) begin
            mdio_i = man_in_val;
        end else if (!mdc_o) begin
            if (mon_active && resp_ack && mon_idx == 47)
                mdio_i = 1'b0;
            else if (mon_active && resp_ack && mon_idx >= 48 && mon_idx < 64)
                mdio_i = resp_data[63 - mon_idx];
            else
                mdio_i = 1'b1;
        end
    end

    task automatic bus_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 40000; i++) begin
            bus_read(2'd1, d);
            if (!d[31]) break;
        end
    endtask

    task automatic mdc_period(output int cyc);
        logic p;
        int   c;
        c = 0;
        @(negedge clk);
        p = mdc_o;
        forever begin
            @(negedge clk);
            if (mdc_o && !p) break;
            p = mdc_o;
        end
        p = mdc_o;
        forever begin
            @(negedge clk);
            c++;
            if (mdc_o && !p) break;
            p = mdc_o;
        end
        cyc = c;
    endtask

    // Driver: pushes expected line image, then issues and completes the frame
    task automatic do_frame(bit wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d, bit ack);
        logic [31:0] r;
        resp_ack  = !wr && ack;
        resp_data = d;
        exp_frame_q.push_back(exp_frame(wr, phy, ra, d, resp_ack));
        exp_oe_q.push_back(wr ? 64 : 46);
        bus_write(2'd1, {1'b1, wr, 1'b0, 3'b000, ra, phy, d});
        bus_read(2'd1, r);
        check("R4 GO reads 1 while frame runs", 64'(r[31]), 64'd1);
        wait_idle();
        bus_read(2'd1, r);
        if (wr)
            check("R6 command word after write", 64'(r), 64'({1'b0, 1'b1, 1'b0, 3'b000, ra, phy, d}));
        else if (resp_ack)
            check("R7 command word after acked read", 64'(r), 64'({1'b0, 1'b0, 1'b1, 3'b000, ra, phy, d}));
        else
            check("R8 command word after unacked read", 64'(r), 64'({1'b0, 1'b0, 1'b0, 3'b000, ra, phy, 16'hFFFF}));
    endtask

    initial begin
        #2_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          per;
        int          frames0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(2'd0, r);
        check("R1 reset control word", 64'(r), 64'h8000_00FF);
        check("R1 reset pins mdc/oe", 64'({mdc_o, mdio_oe}), 64'd0);

        // R4 GO ignored while disabled
        bus_write(2'd1, 32'h8000_0000);
        bus_read(2'd1, r);
        check("R4 GO ignored when disabled", 64'(r[31]), 64'd0);

        // R2 enable, divider 3
        bus_write(2'd0, 32'h4000_0003);
        bus_read(2'd0, r);
        check("R2 control word when enabled", 64'(r), 64'h4000_0003);

        // R3 period
        mdc_period(per);
        mdc_period(per);
        check("R3 period with divider 3", 64'(per), 64'd4);
        bus_write(2'd0, 32'h4000_0000);
        mdc_period(per);
        mdc_period(per);
        check("R3 divider 0 treated as 1", 64'(per), 64'd2);
        bus_write(2'd0, 32'h4000_0003);
        repeat (10) @(negedge clk);

        // R5 R6 write frame
        do_frame(1'b1, 5'h13, 5'h0A, 16'hA5C3, 1'b0);
        // R7 acked reads
        do_frame(1'b0, 5'h01, 5'h1F, 16'h1234, 1'b1);
        do_frame(1'b0, 5'h00, 5'h00, 16'h8001, 1'b1);
        // R8 unacked read
        do_frame(1'b0, 5'h1C, 5'h02, 16'h5555, 1'b0);

        // R12 second GO while busy is dropped
        frames0   = mon_frames;
        resp_ack  = 1'b0;
        exp_frame_q.push_back(exp_frame(1'b1, 5'h05, 5'h11, 16'h0F0F, 1'b0));
        exp_oe_q.push_back(64);
        bus_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b000, 5'h11, 5'h05, 16'h0F0F});
        repeat (5) @(negedge clk);
        bus_write(2'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'h07, 5'h1A, 16'hBEEF});
        wait_idle();
        bus_read(2'd1, r);
        check("R12 fields kept after busy write", 64'(r), 64'({1'b0, 1'b1, 1'b0, 3'b000, 5'h11, 5'h05, 16'h0F0F}));
        repeat (300) @(negedge clk);
        check("R12 exactly one frame produced", 64'(mon_frames - frames0), 64'd1);
        check("R12 scoreboard drained", 64'(exp_frame_q.size()), 64'd0);

        // R9 data moved only on falling MDC
        check("R9 data changes away from MDC fall", 64'(edge_viol), 64'd0);

        // R10 abort
        mon_kill = 1'b1;
        bus_write(2'd1, {1'b1, 1'b0, 1'b0, 3'b000, 5'h03, 5'h04, 16'h0000});
        repeat (80) @(negedge clk);
        bus_write(2'd0, 32'h0000_0003);
        @(negedge clk);
        check("R10 pins after abort mdc/oe", 64'({mdc_o, mdio_oe}), 64'd0);
        bus_read(2'd1, r);
        check("R10 GO cleared by abort", 64'(r[31]), 64'd0);
        bus_read(2'd0, r);
        check("R10 R2 idle flag when disabled", 64'(r), 64'h8000_0003);
        repeat (20) @(negedge clk);
        check("R10 MDC stays low while disabled", 64'(mdc_o), 64'd0);
        mon_kill = 1'b0;
        bus_write(2'd0, 32'h4000_0003);
        repeat (10) @(negedge clk);
        do_frame(1'b1, 5'h1F, 5'h15, 16'h6C39, 1'b0);

        // R11 manual mode
        mon_kill   = 1'b1;
        man_in_en  = 1'b1;
        man_in_val = 1'b1;
        bus_write(2'd2, 32'h8000_0000);
        bus_read(2'd0, r);
        check("R11 R2 idle flag in manual mode", 64'(r), 64'hC000_0003);
        bus_write(2'd3, 32'h0000_0006);
        @(negedge clk);
        check("R11 pins follow bits mdc/oe/data", 64'({mdc_o, mdio_oe, mdio_o}), 64'b110);
        bus_read(2'd3, r);
        check("R11 bit0 returns written value when oe=1", 64'(r[2:0]), 64'b110);
        bus_write(2'd3, 32'h0000_0001);
        man_in_val = 1'b0;
        @(negedge clk);
        bus_read(2'd3, r);
        check("R11 bit0 returns line low when oe=0", 64'(r[2:0]), 64'b000);
        man_in_val = 1'b1;
        @(negedge clk);
        bus_read(2'd3, r);
        check("R11 bit0 returns line high when oe=0", 64'(r[2:0]), 64'b001);
        bus_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b000, 5'h01, 5'h01, 16'h0001});
        bus_read(2'd1, r);
        check("R11 GO ignored in manual mode", 64'(r[31]), 64'd0);
        repeat (20) @(negedge clk);
        check("R11 pins unchanged after GO", 64'({mdc_o, mdio_oe, mdio_o}), 64'b001);

        // back to engine mode
        bus_write(2'd2, 32'h0000_0000);
        man_in_en = 1'b0;
        repeat (4) @(negedge clk);
        mon_kill = 1'b0;
        repeat (10) @(negedge clk);
        do_frame(1'b0, 5'h0E, 5'h19, 16'h3AC5, 1'b1);
        repeat (20) @(negedge clk);
        check("R5 scoreboard empty at end", 64'(exp_frame_q.size()), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule